// File: doc/BRIEF.md
# Reseedable LFSR Scan Stimulus Expander

This block produces shift-in data for four parallel scan chains. A 16-bit linear feedback shift register drives a spreading network of XOR gates, and each chain input is the XOR of three register bits. Two flip-flops near the head of chain 0 are fed back into the register. Once the chain has filled past those cells, they behave as extra generator state. The block holds a model of the scan chains, so those feedback cells and the chain outputs can be seen at its ports.

A one-cycle `start` pulse begins a pattern. The `mode_det` input selects one of two modes:

- **Deterministic mode** (`mode_det` = 1): the register and the chains are cleared. A seed of `seed_len` bits is then shifted in serially from `tdi`. The seed fills the register first and then spills into the head of chain 0. After that, the structure expands the seed in parallel for 32 shift cycles, which fills every chain.
- **Pseudorandom mode** (`mode_det` = 0): the register keeps running from its current state, and no seed is loaded.

A `done` pulse marks the end of every pattern.

Top module: `seed_expander`

## Requirements
- R1: After reset, `load_active`, `shift_en`, `done`, `chain_di` and `chain_so` are all 0, and the register and all chain cells are 0.
- R2: A `start` accepted with `mode_det`=1 clears the register and chains, then holds `load_active` high for exactly `seed_len` cycles, capturing one `tdi` bit at the end of each of those cycles.
- R3: Seed path order: each captured `tdi` bit enters register bit 0. Register bits move up by one, and register bit 15 moves into cell 0 of chain 0. Positions the seed never reaches stay 0.
- R4: During each expansion cycle, `chain_di[c]` equals the XOR of register bits c, (c+5) mod 16 and (c+11) mod 16.
- R5: On each expansion shift, the register moves up by one. Its new bit 0 is the XOR of register bits 15, 13, 12 and 10, further XORed with chain 0 cells 3 and 7.
- R6: On each expansion shift, every chain moves toward its last cell and takes `chain_di[c]` into cell 0. `chain_so[c]` shows cell 31 of chain c.
- R7: Expansion lasts exactly 32 cycles with `shift_en` high. `done` is then high for one cycle, after which the block is idle. `load_active` and `shift_en` are never high together.
- R8: A `start` accepted with `mode_det`=0 loads no seed and goes straight to expansion. The register continues from its current state, except that an all-zero register is replaced by 16'hACE1. Chain contents are kept.
- R9: A deterministic start with `seed_len`=0 loads nothing and expands an all-zero state, so every `chain_di` bit is 0.
- R10: `start` is ignored while a load or an expansion is in progress.
- R11: A `seed_len` above 24 is treated as 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_det | input | 1 | 1 = deterministic seed mode, 0 = pseudorandom mode; sampled with start |
| start | input | 1 | Begin a pattern; honoured only when idle |
| tdi | input | 1 | Serial seed data |
| seed_len | input | 6 | Number of seed bits to load, limited to 24 |
| load_active | output | 1 | High during each seed capture cycle |
| shift_en | output | 1 | High during each expansion shift cycle |
| done | output | 1 | One-cycle pulse after the last shift |
| chain_di | output | 4 | Data entering each scan chain this cycle |
| chain_so | output | 4 | Last cell of each scan chain |

## Verification
The hardest behaviour to reach is the extra feedback from chain 0 cells 3 and 7. Those cells only change the register sequence when they hold ones during expansion. That happens in two ways: a seed longer than 16 bits places values there directly, or expansion itself carries ones into them within the first few shifts. The directed tests therefore use seeds of 20 and 24 bits with ones in the spill-over part. They also run pseudorandom patterns back to back, so that chain contents left over from earlier patterns feed back. A start pulse held during expansion, a zero-length seed and an over-long length complete the corner cases. Each test is compared bit by bit against a separate model.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
  parameter int LFSR_W   = 16;
  parameter int N_CH     = 4;
  parameter int CH_LEN   = 32;
  parameter int HEAD_LEN = 8;
  parameter int N_XFB    = 2;
  parameter int MAX_SEED = LFSR_W + HEAD_LEN;
  parameter int LEN_W    = $clog2(MAX_SEED + 1) + 1;
  parameter int CNT_W    = $clog2(((CH_LEN > MAX_SEED) ? CH_LEN : MAX_SEED) + 1);
  parameter logic [LFSR_W-1:0] POLY_MASK = 16'hB400;
  parameter logic [LFSR_W-1:0] PR_SEED   = 16'hACE1;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_EXPAND, ST_DONE} seq_st_e;

  function automatic int xfb_cell(input int k);
    return (k == 0) ? 3 : 7;
  endfunction

  function automatic int ps_tap(input int c, input int k);
    int off;
    case (k)
      0: off = 0;
      1: off = 5;
      default: off = 11;
    endcase
    return (c + off) % LFSR_W;
  endfunction

  function automatic logic lfsr_fb(input logic [LFSR_W-1:0] s);
    return ^(s & POLY_MASK);
  endfunction

  function automatic logic ps_bit(input logic [LFSR_W-1:0] s, input int c);
    return s[ps_tap(c, 0)] ^ s[ps_tap(c, 1)] ^ s[ps_tap(c, 2)];
  endfunction
endpackage

// File: rtl/dcmp_seq.sv
module dcmp_seq
  import dcmp_pkg::*;
#(
  parameter int P_CH_LEN   = CH_LEN,
  parameter int P_MAX_SEED = MAX_SEED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_det,
  input  logic [LEN_W-1:0] seed_len,
  output logic             load_active,
  output logic             shift_en,
  output logic             done,
  output logic             clear_det,
  output logic             pr_kick
);
  seq_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_clamped;
  logic             accept;

  assign len_clamped = (seed_len > LEN_W'(P_MAX_SEED)) ? LEN_W'(P_MAX_SEED) : seed_len;
  assign accept      = (st == ST_IDLE) && start;
  assign clear_det   = accept && mode_det;
  assign pr_kick     = accept && !mode_det;
  assign load_active = (st == ST_LOAD);
  assign shift_en    = (st == ST_EXPAND);
  assign done        = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      len_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          cnt   <= '0;
          len_q <= len_clamped;
          st    <= (mode_det && len_clamped != '0) ? ST_LOAD : ST_EXPAND;
        end
        ST_LOAD: begin
          if (CNT_W'(len_q) == cnt + CNT_W'(1)) begin
            cnt <= '0;
            st  <= ST_EXPAND;
          end else cnt <= cnt + CNT_W'(1);
        end
        ST_EXPAND: begin
          if (cnt == CNT_W'(P_CH_LEN - 1)) begin
            cnt <= '0;
            st  <= ST_DONE;
          end else cnt <= cnt + CNT_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7
  lane_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_active, shift_en, done}));
  // R7
  done_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(shift_en));
  // R2
  load_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_active |-> (CNT_W'(len_q) > cnt));
  // R8
  pr_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pr_kick |=> (shift_en && !load_active));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && start && cnt != CNT_W'(P_CH_LEN - 1)) |=> shift_en);
endmodule

// File: rtl/dcmp_lfsr_core.sv
module dcmp_lfsr_core
  import dcmp_pkg::*;
#(
  parameter int P_W     = LFSR_W,
  parameter int P_N_XFB = N_XFB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               pr_kick,
  input  logic               load,
  input  logic               shift,
  input  logic               tdi,
  input  logic [P_N_XFB-1:0] xfb,
  output logic [P_W-1:0]     state,
  output logic               spill_bit
);
  logic fb_bit;

  assign fb_bit    = lfsr_fb(state) ^ (^xfb);
  assign spill_bit = state[P_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       state <= '0;
    else if (clear)                   state <= '0;
    else if (pr_kick && state == '0)  state <= PR_SEED;
    else if (load)                    state <= {state[P_W-2:0], tdi};
    else if (shift)                   state <= {state[P_W-2:0], fb_bit};
  end

  // R3
  seed_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state[0] == $past(tdi));
  // R5
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> state[P_W-1:1] == $past(state[P_W-2:0]));
  // R8
  pr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pr_kick |=> state != '0);
endmodule

// File: rtl/dcmp_phase_shifter.sv
module dcmp_phase_shifter
  import dcmp_pkg::*;
#(
  parameter int P_W    = LFSR_W,
  parameter int P_N_CH = N_CH
) (
  input  logic [P_W-1:0]    state,
  output logic [P_N_CH-1:0] di
);
  for (genvar c = 0; c < P_N_CH; c++) begin : g_ch
    assign di[c] = ps_bit(state, c);
  end
endmodule

// File: rtl/dcmp_scan_chains.sv
module dcmp_scan_chains
  import dcmp_pkg::*;
#(
  parameter int P_N_CH   = N_CH,
  parameter int P_CH_LEN = CH_LEN,
  parameter int P_N_XFB  = N_XFB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               load,
  input  logic               shift,
  input  logic               load_bit,
  input  logic [P_N_CH-1:0]  di,
  output logic [P_N_CH-1:0]  so,
  output logic [P_N_XFB-1:0] xfb
);
  logic [P_CH_LEN-1:0] cells [P_N_CH];

  for (genvar c = 0; c < P_N_CH; c++) begin : g_chain
    logic head_in;
    logic mv;
    if (c == 0) begin : g_head
      assign head_in = shift ? di[c] : load_bit;
      assign mv      = shift | load;
    end else begin : g_body
      assign head_in = di[c];
      assign mv      = shift;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cells[c] <= '0;
      else if (clear) cells[c] <= '0;
      else if (mv)    cells[c] <= {cells[c][P_CH_LEN-2:0], head_in};
    end

    assign so[c] = cells[c][P_CH_LEN-1];

    // R6
    chain_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !clear) |=> cells[c][0] == $past(di[c]));
  end

  for (genvar k = 0; k < P_N_XFB; k++) begin : g_xfb
    assign xfb[k] = cells[0][xfb_cell(k)];
  end
endmodule

// File: rtl/seed_expander.sv
module seed_expander
  import dcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_det,
  input  logic             start,
  input  logic             tdi,
  input  logic [LEN_W-1:0] seed_len,
  output logic             load_active,
  output logic             shift_en,
  output logic             done,
  output logic [N_CH-1:0]  chain_di,
  output logic [N_CH-1:0]  chain_so
);
  logic              clear_det;
  logic              pr_kick;
  logic [LFSR_W-1:0] lfsr_q;
  logic              spill_bit;
  logic [N_XFB-1:0]  xfb;
  logic [N_CH-1:0]   ps_out;

  dcmp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_det(mode_det),
    .seed_len(seed_len), .load_active(load_active), .shift_en(shift_en),
    .done(done), .clear_det(clear_det), .pr_kick(pr_kick)
  );

  dcmp_lfsr_core u_lfsr (
    .clk(clk), .rst_n(rst_n), .clear(clear_det), .pr_kick(pr_kick),
    .load(load_active), .shift(shift_en), .tdi(tdi), .xfb(xfb),
    .state(lfsr_q), .spill_bit(spill_bit)
  );

  dcmp_phase_shifter u_ps (.state(lfsr_q), .di(ps_out));

  dcmp_scan_chains u_chains (
    .clk(clk), .rst_n(rst_n), .clear(clear_det), .load(load_active),
    .shift(shift_en), .load_bit(spill_bit), .di(ps_out), .so(chain_so),
    .xfb(xfb)
  );

  assign chain_di = shift_en ? ps_out : '0;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |-> chain_di == '0);
endmodule

// File: tb/seed_expander_tb.sv
`timescale 1ns/1ps
module seed_expander_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_det = 1'b0;
  logic       start = 1'b0;
  logic       tdi = 1'b0;
  logic [5:0] seed_len = '0;
  logic       load_active, shift_en, done;
  logic [3:0] chain_di, chain_so;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [15:0] m_lfsr;
  logic [31:0] m_ch [4];

  always #2.5 clk = ~clk;

  seed_expander u_dut (
    .clk(clk), .rst_n(rst_n), .mode_det(mode_det), .start(start), .tdi(tdi),
    .seed_len(seed_len), .load_active(load_active), .shift_en(shift_en),
    .done(done), .chain_di(chain_di), .chain_so(chain_so)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] m_spread(input logic [15:0] s);
    logic [3:0] r;
    r[0] = s[0] ^ s[5]  ^ s[11];
    r[1] = s[1] ^ s[6]  ^ s[12];
    r[2] = s[2] ^ s[7]  ^ s[13];
    r[3] = s[3] ^ s[8]  ^ s[14];
    return r;
  endfunction

  task automatic m_clear();
    m_lfsr = '0;
    for (int c = 0; c < 4; c++) m_ch[c] = '0;
  endtask

  task automatic m_shift();
    logic [3:0] d;
    logic nb;
    d  = m_spread(m_lfsr);
    nb = m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10] ^ m_ch[0][3] ^ m_ch[0][7];
    for (int c = 0; c < 4; c++) m_ch[c] = {m_ch[c][30:0], d[c]};
    m_lfsr = {m_lfsr[14:0], nb};
  endtask

  task automatic issue(input logic md, input logic [5:0] len);
    @(negedge clk);
    mode_det = md; seed_len = len; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic load_seed(input logic [31:0] bits, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(load_active === 1'b1, req, {31'd0, load_active}, 32'd1);
      tdi = bits[i];
      m_ch[0] = {m_ch[0][30:0], m_lfsr[15]};
      m_lfsr  = {m_lfsr[14:0], bits[i]};
      @(negedge clk);
    end
    tdi = 1'b0;
    chk(load_active === 1'b0, req, {31'd0, load_active}, 32'd0);
  endtask

  task automatic expand(input string req, input bit poke);
    for (int k = 0; k < 32; k++) begin
      chk(shift_en === 1'b1 && chain_di === m_spread(m_lfsr), req,
          {27'd0, shift_en, chain_di}, {27'd1, m_spread(m_lfsr)});
      if (poke && k == 3) begin start = 1'b1; mode_det = 1'b1; seed_len = 6'd5; end
      if (poke && k == 12) start = 1'b0;
      m_shift();
      @(negedge clk);
    end
    chk(done === 1'b1 && shift_en === 1'b0, "R7 done pulse", {30'd0, done, shift_en}, 32'd2);
    @(negedge clk);
    chk(done === 1'b0 && shift_en === 1'b0 && load_active === 1'b0, "R7 back to idle",
        {29'd0, done, shift_en, load_active}, 32'd0);
    chk(chain_so === {m_ch[3][31], m_ch[2][31], m_ch[1][31], m_ch[0][31]}, "R6 chain_so",
        {28'd0, chain_so}, {28'd0, m_ch[3][31], m_ch[2][31], m_ch[1][31], m_ch[0][31]});
  endtask

  task automatic t_reset();
    m_clear();
    chk(load_active === 1'b0 && shift_en === 1'b0 && done === 1'b0, "R1 controls",
        {29'd0, load_active, shift_en, done}, 32'd0);
    chk(chain_di === 4'd0 && chain_so === 4'd0, "R1 data", {24'd0, chain_di, chain_so}, 32'd0);
  endtask

  task automatic t_det(input logic [31:0] bits, input int n, input string req);
    issue(1'b1, 6'(n));
    m_clear();
    load_seed(bits, n, {req, " R2 load"});
    expand({req, " R4 R5 expansion"}, 1'b0);
  endtask

  task automatic t_zero();
    issue(1'b1, 6'd0);
    m_clear();
    chk(load_active === 1'b0, "R9 no load", {31'd0, load_active}, 32'd0);
    expand("R9 zero seed", 1'b0);
  endtask

  task automatic t_pr(input string req);
    issue(1'b0, 6'd20);
    chk(load_active === 1'b0, "R8 no load", {31'd0, load_active}, 32'd0);
    if (m_lfsr == 16'h0) m_lfsr = 16'hACE1;
    expand(req, 1'b0);
  endtask

  task automatic t_clamp();
    issue(1'b1, 6'd30);
    m_clear();
    load_seed(32'h3F00_96C5, 24, "R11 clamp to 24");
    expand("R11 expansion after clamp", 1'b0);
  endtask

  task automatic t_busy();
    issue(1'b0, 6'd0);
    expand("R10 start ignored while busy", 1'b1);
    mode_det = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_det(32'h0000_1234, 16, "R3 16-bit seed");
    t_det(32'h00A5_3C7E, 24, "R3 24-bit seed into chain head");
    t_det(32'h000F_8001, 20, "R3 20-bit partial head");
    t_zero();
    t_pr("R8 pseudorandom from zero");
    t_pr("R8 pseudorandom continued");
    t_clamp();
    t_busy();
    t_det(32'h0000_0001, 1, "R2 one-bit seed");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule